// File: doc/BRIEF.md
# Hash-Bucket Egress Mask Generator for Link Aggregation

This block works out which local switch ports may send a frame, for each of eight hash buckets, when traffic is spread over link-aggregation groups. Every port carries three configuration inputs: a flag that says it belongs to a group, a 4-bit group number, and a flag that says it may transmit. Ports outside every group are allowed in all buckets. The buckets of each group are shared out among its transmit-enabled members, using a fixed uneven split that depends only on how many members are active.

A recompute starts when any configuration input changes or when the strobe input is pulsed. The block then takes a copy of the configuration. It walks the group numbers one per cycle and builds the eight masks in internal registers. It then sends them out as eight consecutive 16-bit register-write words, bucket 0 first, and raises a one-cycle done flag. The receiving mask table takes each word as it arrives. A change that arrives while a recompute is running is remembered, and a fresh recompute follows the current one.

Top module: `lag_bucket_mask_gen`

## Requirements
- R1: After reset a recompute runs on its own; with no group members all eight words carry every valid port bit set.
- R2: A port whose membership flag is low has its bit set in all eight bucket masks.
- R3: A member port has its bit cleared in every bucket except those given to it as an active member; a member with transmit disabled gets no bucket, and a group with no active member adds no bit anywhere.
- R4: Within one group number, active members are ranked 0, 1, 2 and so on by ascending port index. With k active members, the member of rank n gets the bucket set (bit i = bucket i) from this split: k=1 {ff}; k=2 {0f,f0}; k=3 {07,38,c0}; k=4 {03,0c,30,c0}; k=5 {03,0c,30,40,80}; k=6 {03,0c,10,20,40,80}; k=7 {03,04,08,10,20,40,80}; k=8: rank n gets only bucket n.
- R5: An active count above 8 is treated as 8, and members of rank 8 or higher get no bucket.
- R6: Each word holds the bucket index in bits 15:12 (bit 15 is always 0), a hash-enable flag of 1 in bit 11, the port mask in bits NPORTS-1:0 (bit p = port p), and zero in every other bit.
- R7: A recompute sends exactly eight words on eight consecutive cycles with the write valid high, buckets 0 to 7 in order. Done is high for exactly the one cycle after the last word.
- R8: A change of any membership, group-number or transmit-enable input, or a pulse on the strobe, starts a recompute. With no such event no word is written.
- R9: The words of a recompute reflect the inputs that were present when it started. A change during a recompute does not alter its words, and causes one more recompute after it.
- R10: Members with different group numbers are ranked and shared out independently of each other, even when their ports are interleaved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| recalc | input | 1 | Strobe that forces a recompute |
| grp_member | input | NPORTS | Per-port group membership flag |
| grp_id | input | NPORTS*IDW | Per-port group number, port p in bits p*IDW +: IDW |
| grp_tx_en | input | NPORTS | Per-port transmit-enable flag |
| wr_valid | output | 1 | Mask-table write strobe |
| wr_data | output | 16 | Mask-table write word |
| done | output | 1 | One-cycle pulse after the last write |

## Verification
Directed cases walk a single group through every active count from one to eight on the lowest ports. This separates each row of the split and shows the rank order. A group of ten active ports probes the clamp. Groups with transmit-disabled members, and groups whose ports are interleaved with another group, show that rank follows active members only and that groups do not interact. A recompute triggered by the strobe with no change, a long quiet stretch, and a change injected halfway through a scan tell the three trigger paths apart and show the snapshot rule. Seeded random configurations over a few group numbers then compare every word against a model of the rules written in the bench.

// File: rtl/lag_mask_pkg.sv
package lag_mask_pkg;

   localparam int NBKT = 8;
   localparam int BKW  = 3;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_SCAN  = 2'd1,
      S_WRITE = 2'd2,
      S_DONE  = 2'd3
   } gen_state_e;

   // Buckets given to the member of rank n among k active members.
   // Byte n of each row is that member's share.
   function automatic logic [7:0] bucket_share(input logic [4:0] k, input logic [4:0] n);
      logic [63:0] row;
      case (k)
         5'd1:    row = 64'h0000_0000_0000_00ff;
         5'd2:    row = 64'h0000_0000_0000_f00f;
         5'd3:    row = 64'h0000_0000_00c0_3807;
         5'd4:    row = 64'h0000_0000_c030_0c03;
         5'd5:    row = 64'h0000_0080_4030_0c03;
         5'd6:    row = 64'h0000_8040_2010_0c03;
         5'd7:    row = 64'h0080_4020_1008_0403;
         5'd8:    row = 64'h8040_2010_0804_0201;
         default: row = 64'h0;
      endcase
      if (n < k && n < 5'd8)
         return row[{n[2:0], 3'b000} +: 8];
      return 8'h00;
   endfunction

endpackage

// File: rtl/lag_change_detect.sv
module lag_change_detect #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] cfg,
   output logic         changed
);
   logic [W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= cfg;
   end

   assign changed = (cfg != prev_q);

endmodule

// File: rtl/lag_rank_share.sv
module lag_rank_share
   import lag_mask_pkg::*;
#(
   parameter int NPORTS = 11
) (
   input  logic [NPORTS-1:0]      act,
   output logic [NBKT*NPORTS-1:0] contrib
);
   localparam int CW = $clog2(NPORTS + 1);

   logic [CW-1:0] rank [NPORTS];
   logic [CW-1:0] total;
   logic [4:0]    k_eff;

   always_comb begin
      total = '0;
      for (int p = 0; p < NPORTS; p++) begin
         rank[p] = total;
         if (act[p]) total = total + CW'(1);
      end
   end

   assign k_eff = (5'(total) > 5'd8) ? 5'd8 : 5'(total);

   for (genvar p = 0; p < NPORTS; p++) begin : g_port
      logic [7:0] share;
      assign share = bucket_share(k_eff, 5'(rank[p]));
      for (genvar b = 0; b < NBKT; b++) begin : g_bkt
         assign contrib[b*NPORTS + p] = act[p] & share[b];
      end
   end

endmodule

// File: rtl/lag_word_fmt.sv
module lag_word_fmt
   import lag_mask_pkg::*;
#(
   parameter int NPORTS = 11
) (
   input  logic [BKW-1:0]    bucket,
   input  logic [NPORTS-1:0] mask,
   output logic [15:0]       word
);
   assign word = {1'b0, bucket, 1'b1, 11'(mask)};
endmodule

// File: rtl/lag_bucket_mask_gen.sv
module lag_bucket_mask_gen
   import lag_mask_pkg::*;
#(
   parameter int NPORTS = 11,
   parameter int NLAGS  = 16,
   parameter int IDW    = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  recalc,
   input  logic [NPORTS-1:0]     grp_member,
   input  logic [NPORTS*IDW-1:0] grp_id,
   input  logic [NPORTS-1:0]     grp_tx_en,
   output logic                  wr_valid,
   output logic [15:0]           wr_data,
   output logic                  done
);
   localparam int CFGW = NPORTS * (IDW + 2);
   localparam logic [IDW-1:0] LAST_GRP = IDW'(NLAGS - 1);
   localparam logic [BKW-1:0] LAST_BKT = BKW'(NBKT - 1);

   if (NPORTS < 1 || NPORTS > 11) begin : g_bad_ports
      $error("NPORTS must be 1..11 to fit the write word");
   end
   if (NLAGS < 1 || NLAGS > (1 << IDW)) begin : g_bad_lags
      $error("NLAGS must be 1..2**IDW");
   end

   gen_state_e                        state;
   logic [IDW-1:0]                    grp_q;
   logic [BKW-1:0]                    bkt_q;
   logic                              pending_q;
   logic [NPORTS-1:0]                 snap_mem, snap_tx;
   logic [NPORTS*IDW-1:0]             snap_id;
   logic [NBKT-1:0][NPORTS-1:0]       mask_q;
   logic [NPORTS-1:0]                 act;
   logic [NBKT*NPORTS-1:0]            contrib;
   logic                              changed, trigger;

   lag_change_detect #(.W(CFGW)) u_chg (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg     ({grp_member, grp_id, grp_tx_en}),
      .changed (changed)
   );

   for (genvar p = 0; p < NPORTS; p++) begin : g_act
      assign act[p] = snap_mem[p] & snap_tx[p] & (snap_id[p*IDW +: IDW] == grp_q);
   end

   lag_rank_share #(.NPORTS(NPORTS)) u_rank (
      .act     (act),
      .contrib (contrib)
   );

   assign trigger = recalc | changed | pending_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         grp_q     <= '0;
         bkt_q     <= '0;
         pending_q <= 1'b1;
         snap_mem  <= '0;
         snap_tx   <= '0;
         snap_id   <= '0;
         mask_q    <= '1;
      end else begin
         case (state)
            S_IDLE: begin
               if (trigger) begin
                  snap_mem  <= grp_member;
                  snap_tx   <= grp_tx_en;
                  snap_id   <= grp_id;
                  for (int b = 0; b < NBKT; b++) mask_q[b] <= ~grp_member;
                  grp_q     <= '0;
                  pending_q <= 1'b0;
                  state     <= S_SCAN;
               end
            end
            S_SCAN: begin
               for (int b = 0; b < NBKT; b++)
                  mask_q[b] <= mask_q[b] | contrib[b*NPORTS +: NPORTS];
               if (grp_q == LAST_GRP) begin
                  bkt_q <= '0;
                  state <= S_WRITE;
               end else begin
                  grp_q <= grp_q + IDW'(1);
               end
            end
            S_WRITE: begin
               if (bkt_q == LAST_BKT) state <= S_DONE;
               else                   bkt_q <= bkt_q + BKW'(1);
            end
            default: state <= S_IDLE;
         endcase
         if (state != S_IDLE && (recalc || changed)) pending_q <= 1'b1;
      end
   end

   lag_word_fmt #(.NPORTS(NPORTS)) u_fmt (
      .bucket (bkt_q),
      .mask   (mask_q[bkt_q]),
      .word   (wr_data)
   );

   assign wr_valid = (state == S_WRITE);
   assign done     = (state == S_DONE);

   // ---------------- assertions ----------------
   for (genvar b = 0; b < NBKT; b++) begin : g_chk
      // R3: only active members of the scanned group contribute
      a_r3_no_foreign: assert property (@(posedge clk) disable iff (!rst_n)
         (state == S_SCAN) |-> ((contrib[b*NPORTS +: NPORTS] & ~act) == '0));
      // R4: each bucket has exactly one owner when a group has active members
      a_r4_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
         (state == S_SCAN && act != '0) |-> ($countones(contrib[b*NPORTS +: NPORTS]) == 1));
   end

   a_r2_nonmember_set: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> ((~snap_mem & ~wr_data[NPORTS-1:0]) == '0));

   a_r6_word_flags: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (wr_data[11] && !wr_data[15]));

   a_r7_first_bucket: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_valid) |-> (wr_data[15:12] == 4'd0));

   a_r7_bucket_order: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && $past(wr_valid)) |-> (wr_data[15:12] == 4'($past(wr_data[15:12]) + 4'd1)));

   a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(wr_valid) && $past(wr_data[15:12]) == 4'd7 && !wr_valid));

   a_r9_masks_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && $past(wr_valid)) |-> $stable(mask_q));

endmodule

// File: tb/tb_lag_bucket_mask_gen.sv
module tb_lag_bucket_mask_gen;
   localparam int NP = 11;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        recalc = 1'b0;
   logic [10:0] grp_member = '0;
   logic [43:0] grp_id = '0;
   logic [10:0] grp_tx_en = '0;
   logic        wr_valid, done;
   logic [15:0] wr_data;

   int total = 0, bad = 0;
   int seqs = 0, vcount = 0, wi = 0, lastn = 0;
   bit prev_v = 0, gap = 0, last_gap = 0, last_done_ok = 0;
   logic [15:0] cur [8];
   logic [15:0] last [8];

   always #10 clk = ~clk;

   lag_bucket_mask_gen dut (
      .clk(clk), .rst_n(rst_n), .recalc(recalc),
      .grp_member(grp_member), .grp_id(grp_id), .grp_tx_en(grp_tx_en),
      .wr_valid(wr_valid), .wr_data(wr_data), .done(done)
   );

   // collect write sequences away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (wr_valid) begin
            if (wi < 8) cur[wi] = wr_data;
            if (wi > 0 && !prev_v) gap = 1;
            wi++;
            vcount++;
         end
         if (done) begin
            for (int i = 0; i < 8; i++) last[i] = cur[i];
            lastn = wi; last_gap = gap; last_done_ok = prev_v;
            wi = 0; gap = 0;
            seqs++;
         end
         prev_v = wr_valid;
      end
   end

   function automatic logic [7:0] tb_share(int k, int n);
      logic [7:0] s;
      s = 8'h00;
      case (k)
         1: if (n == 0) s = 8'hff;
         2: case (n) 0: s = 8'h0f; 1: s = 8'hf0; default: s = 0; endcase
         3: case (n) 0: s = 8'h07; 1: s = 8'h38; 2: s = 8'hc0; default: s = 0; endcase
         4: case (n) 0: s = 8'h03; 1: s = 8'h0c; 2: s = 8'h30; 3: s = 8'hc0; default: s = 0; endcase
         5: case (n) 0: s = 8'h03; 1: s = 8'h0c; 2: s = 8'h30; 3: s = 8'h40; 4: s = 8'h80;
                     default: s = 0; endcase
         6: case (n) 0: s = 8'h03; 1: s = 8'h0c; 2: s = 8'h10; 3: s = 8'h20; 4: s = 8'h40;
                     5: s = 8'h80; default: s = 0; endcase
         7: case (n) 0: s = 8'h03; default: s = (n < 7) ? 8'(1 << (n + 1)) : 8'h00; endcase
         8: s = (n < 8) ? 8'(1 << n) : 8'h00;
         default: s = 8'h00;
      endcase
      return s;
   endfunction

   function automatic logic [15:0] exp_word(int b, logic [10:0] m, logic [43:0] id, logic [10:0] t);
      logic [10:0] mk;
      logic [7:0]  s;
      int k, kc, n;
      mk = ~m;
      for (int g = 0; g < 16; g++) begin
         k = 0;
         for (int p = 0; p < NP; p++)
            if (m[p] && t[p] && id[p*4 +: 4] == 4'(g)) k++;
         kc = (k > 8) ? 8 : k;
         n = 0;
         for (int p = 0; p < NP; p++) begin
            if (m[p] && t[p] && id[p*4 +: 4] == 4'(g)) begin
               s = tb_share(kc, n);
               if (s[b]) mk[p] = 1'b1;
               n++;
            end
         end
      end
      return {1'b0, 3'(b), 1'b1, mk};
   endfunction

   task automatic check(bit ok, string tag, logic [31:0] act_v, logic [31:0] exp_v);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act_v, exp_v);
      end
   endtask

   task automatic wait_seq(string tag);
      int s0, n;
      s0 = seqs; n = 0;
      while (seqs == s0 && n < 400) begin
         @(posedge clk);
         n++;
      end
      check(seqs != s0, {tag, " R8 sequence started"}, 32'(seqs), 32'(s0 + 1));
   endtask

   task automatic expect_seq(string tag, logic [10:0] m, logic [43:0] id, logic [10:0] t);
      logic [15:0] e;
      check(lastn == 8 && !last_gap && last_done_ok, {tag, " R7 eight back-to-back words then done"},
            32'(lastn), 32'd8);
      for (int b = 0; b < 8; b++) begin
         e = exp_word(b, m, id, t);
         check(last[b] === e, $sformatf("%s R6 bucket %0d word", tag, b), 32'(last[b]), 32'(e));
      end
   endtask

   task automatic apply(logic [10:0] m, logic [43:0] id, logic [10:0] t, bit pulse);
      @(negedge clk);
      grp_member = m; grp_id = id; grp_tx_en = t; recalc = pulse;
      @(negedge clk);
      recalc = 1'b0;
   endtask

   task automatic run_case(string tag, logic [10:0] m, logic [43:0] id, logic [10:0] t, bit pulse);
      apply(m, id, t, pulse);
      wait_seq(tag);
      expect_seq(tag, m, id, t);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [10:0] m, t, m2, t2;
      logic [43:0] id, id2;
      int v0, s0;
      void'($urandom(32'd20240611));

      repeat (4) @(negedge clk);
      check(wr_valid === 1'b0 && done === 1'b0, "R1 outputs idle in reset",
            {wr_valid, done}, 32'd0);
      rst_n = 1'b1;

      // R1: automatic run after reset, all ones
      wait_seq("R1 reset run");
      expect_seq("R1 reset run", '0, '0, '0);
      check(last[0][10:0] === 11'h7ff, "R1 all ports in bucket 0", 32'(last[0]), 32'h07ff);

      // R4: one group with k = 1..8 active members on the lowest ports (change only, no strobe)
      for (int k = 1; k <= 8; k++) begin
         m = 11'((1 << k) - 1);
         id = {11{4'd3}};
         run_case($sformatf("R4 k=%0d", k), m, id, m, 1'b0);
      end

      // R4: sparse rank order
      m = 11'b000_0101_0010; id = {11{4'd5}};
      run_case("R4 sparse ports 1,4,6", m, id, m, 1'b1);

      // R5: ten active members, clamp to 8
      m = 11'h3ff; id = {11{4'd2}};
      run_case("R5 clamp ten members", m, id, m, 1'b1);

      // R3: transmit-disabled members and a group with no active member
      m = 11'b001_0110_1100; t = 11'b001_0010_0000;
      id = '0;
      id[2*4 +: 4] = 4'd7; id[3*4 +: 4] = 4'd7;
      id[5*4 +: 4] = 4'd1; id[6*4 +: 4] = 4'd1; id[8*4 +: 4] = 4'd1;
      run_case("R3 tx-disabled members", m, id, t, 1'b1);

      // R10: interleaved groups
      m = 11'b000_0001_1111; t = m;
      id = '0;
      id[1*4 +: 4] = 4'd9; id[3*4 +: 4] = 4'd9;
      run_case("R10 interleaved groups", m, id, t, 1'b1);

      // R8: strobe alone with unchanged inputs
      run_case("R8 strobe only", m, id, t, 1'b1);
      // R8: no event, no writes
      v0 = vcount; s0 = seqs;
      repeat (60) @(negedge clk);
      check(vcount == v0 && seqs == s0, "R8 quiet inputs give no writes", 32'(vcount - v0), 32'd0);

      // R9: change halfway through a scan
      m = 11'h0f0; id = {11{4'd4}}; t = 11'h0f0;
      m2 = 11'h00f; id2 = {11{4'd6}}; t2 = 11'h007;
      apply(m, id, t, 1'b1);
      repeat (5) @(negedge clk);
      grp_member = m2; grp_id = id2; grp_tx_en = t2;
      wait_seq("R9 first run");
      expect_seq("R9 first run uses old inputs", m, id, t);
      wait_seq("R9 second run");
      expect_seq("R9 second run uses new inputs", m2, id2, t2);

      // random configurations over a few group numbers
      for (int r = 0; r < 30; r++) begin
         m = 11'($urandom);
         t = 11'($urandom | $urandom);
         for (int p = 0; p < NP; p++) id[p*4 +: 4] = 4'($urandom_range(3, 0));
         run_case($sformatf("R4 R10 random %0d", r), m, id, t, 1'b1);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule